// File: doc/BRIEF.md
# Half-Word Multiply-Add Unit

This block is a 32-bit integer arithmetic stage. It takes a 16-bit half from each of its first two operands, widens each half to 32 bits, multiplies the two, and adds a third operand. A 7-bit control word picks the half of each multiplicand. It can also shift the product up by sixteen places, merge the second operand's low half into the top of the result, or restrict the addend to one half of the third operand. Two more codes apply a sign correction to the result or add the second operand shifted up by sixteen.

The unit is intended for a compute pipeline. There, wide multiplies are made from several such half-word steps. The caller presents the operands with a one-cycle valid strobe and takes the registered result one clock later. Two flags mark the first and second operands as immediates. The unit then reports, alongside the result, whether that immediate use is illegal.

Top module: `hmad_unit`

## Requirements
- R1: Control bit 5 selects bits 31:16 of `op_a` as the first multiplicand instead of bits 15:0. Control bit 6 does the same for `op_b`.
- R2: When `is_signed` is 1, each selected half is sign-extended to 32 bits before multiplying. When it is 0, each half is zero-extended.
- R3: With carry code (control bits 4:2) equal to 0 and bits 1:0 clear, the result is the product plus `op_c`, modulo 2^32.
- R4: Control bit 0 (post-shift) makes the result the product shifted left by 16, plus the addend chosen by the carry code, modulo 2^32.
- R5: Control bit 1 (merge) makes result bits 15:0 equal to bits 15:0 of the multiply-add value and result bits 31:16 equal to `op_b[15:0]`.
- R6: Carry code 1 adds only `op_c[15:0]`, zero-extended. Carry code 2 adds only `op_c[31:16]`, zero-extended.
- R7: Carry code 3 adds the full `op_c`. When both selected halves are non-zero, it then subtracts 65536 once for each selected half that is negative, where negative means signed mode with bit 15 of the half set.
- R8: Carry code 4 adds `op_c` and also `op_b[15:0]` shifted left by 16.
- R9: Carry codes 5, 6 and 7 behave exactly as code 0.
- R10: When merge is clear and the carry code is not 4, swapping `op_a` with `op_b` and swapping control bits 5 and 6 leaves the result unchanged.
- R11: `out_illegal` is 1 when an operand flagged as immediate has a non-zero upper half or has its high-half control bit set. Otherwise it is 0.
- R12: Outputs update on the clock edge that samples `in_valid` high and hold while `in_valid` is low. `out_valid` is high for exactly the one cycle after each strobe. A synchronous low `rst_n` clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | First multiplicand word |
| op_b | input | 32 | Second multiplicand word, also used by merge and carry code 4 |
| op_c | input | 32 | Addend word |
| is_signed | input | 1 | 1 sign-extends the selected halves |
| mode | input | 7 | Control word: bit0 post-shift, bit1 merge, bits4:2 carry code, bit5 high half of op_a, bit6 high half of op_b |
| imm_a | input | 1 | op_a comes from an immediate |
| imm_b | input | 1 | op_b comes from an immediate |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Registered result |
| out_illegal | output | 1 | Registered illegal-immediate indication |

## Verification
The sign correction is the hardest case to reach. It applies only in signed mode, only when both selected halves are non-zero, and only to halves with bit 15 set. A selected half of zero must cancel it even when the other half is negative. Directed cases cover each of these combinations: one negative, two negative, a zero paired with a negative, and the same values unsigned. The swap property is driven as pairs of transactions whose high-half flags are exchanged, and the two returned results are compared directly.

// File: rtl/hmad_pkg.sv
// Shared widths, control-word layout and carry-code values for the
// half-word multiply-add unit. Assumes a 32-bit word split into two halves.
package hmad_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int MODE_W = 7;
    localparam int CODE_W = 3;

    // Carry codes held in control bits 4:2
    localparam logic [CODE_W-1:0] CC_PLAIN  = 3'd0;
    localparam logic [CODE_W-1:0] CC_LOHALF = 3'd1;
    localparam logic [CODE_W-1:0] CC_HIHALF = 3'd2;
    localparam logic [CODE_W-1:0] CC_SFIX   = 3'd3;
    localparam logic [CODE_W-1:0] CC_BSHIFT = 3'd4;

    // Control word, MSB first: bit6 .. bit0
    typedef struct packed {
        logic              hi_b;
        logic              hi_a;
        logic [CODE_W-1:0] code;
        logic              merge;
        logic              post_shift;
    } ctrl_t;
endpackage

// File: rtl/hmad_half_pick.sv
// Picks one half of an operand word and widens it to the full word.
// Also reports whether the picked half is zero or negative, and whether
// an immediate use of this operand is illegal.
// Assumes WORD_W is even.
module hmad_half_pick #(
    parameter int WORD_W = hmad_pkg::WORD_W,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              take_hi,
    input  logic              sgn,
    input  logic              is_imm,
    output logic [WORD_W-1:0] wide,
    output logic              nonzero,
    output logic              negative,
    output logic              bad_imm
);
    logic [HALF_W-1:0] half;

    // Select the requested half and extend it
    always_comb begin
        half     = take_hi ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
        wide     = {{HALF_W{sgn & half[HALF_W-1]}}, half};
        nonzero  = |half;
        negative = sgn & half[HALF_W-1];
    end

    // An immediate may not use its high half and must fit in the low half
    always_comb begin
        bad_imm = is_imm & (take_hi | (|word[WORD_W-1:HALF_W]));
    end
endmodule

// File: rtl/hmad_addend.sv
// Forms the addend from the third operand according to the carry code.
// Codes 1 and 2 take one zero-extended half. Every other code passes
// the full word through.
module hmad_addend #(
    parameter int WORD_W = hmad_pkg::WORD_W,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [hmad_pkg::CODE_W-1:0] code,
    input  logic [WORD_W-1:0]           op_c,
    output logic [WORD_W-1:0]           addend
);
    import hmad_pkg::*;

    // Choose full word or one zero-extended half
    always_comb begin
        unique case (code)
            CC_LOHALF: addend = {{HALF_W{1'b0}}, op_c[HALF_W-1:0]};
            CC_HIHALF: addend = {{HALF_W{1'b0}}, op_c[WORD_W-1:HALF_W]};
            default:   addend = op_c;
        endcase
    end
endmodule

// File: rtl/hmad_combine.sv
// Multiplies the two widened halves and applies the shift, addend,
// sign correction, shifted second-operand add and merge, in that order.
// All sums wrap at the word width.
module hmad_combine #(
    parameter int WORD_W = hmad_pkg::WORD_W,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0]           wide_a,
    input  logic [WORD_W-1:0]           wide_b,
    input  logic [WORD_W-1:0]           addend,
    input  logic [WORD_W-1:0]           op_b,
    input  hmad_pkg::ctrl_t             ctrl,
    input  logic [1:0]                  nonzero,
    input  logic [1:0]                  negative,
    output logic [WORD_W-1:0]           result
);
    import hmad_pkg::*;

    logic [2*WORD_W-1:0] full_prod;
    logic [WORD_W-1:0]   prod;
    logic [WORD_W-1:0]   base;
    logic [WORD_W-1:0]   fix;
    logic [WORD_W-1:0]   bsh;
    logic [WORD_W-1:0]   mac;
    logic [1:0]          neg_cnt;

    // Low word of the product of the widened halves
    always_comb begin
        full_prod = wide_a * wide_b;
        prod      = full_prod[WORD_W-1:0];
    end

    // Optional post-shift of the product, then the addend
    always_comb begin
        if (ctrl.post_shift)
            base = {prod[HALF_W-1:0], {HALF_W{1'b0}}} + addend;
        else
            base = prod + addend;
    end

    // Sign correction: 2^HALF_W per negative half when both halves are non-zero
    always_comb begin
        neg_cnt = {1'b0, negative[0]} + {1'b0, negative[1]};
        fix     = '0;
        if (ctrl.code == CC_SFIX && (&nonzero))
            fix = {{(WORD_W-HALF_W-2){1'b0}}, neg_cnt, {HALF_W{1'b0}}};
    end

    // Shifted second operand for carry code 4
    always_comb begin
        bsh = '0;
        if (ctrl.code == CC_BSHIFT)
            bsh = {op_b[HALF_W-1:0], {HALF_W{1'b0}}};
    end

    // Final sum and optional merge with the second operand
    always_comb begin
        mac = base - fix + bsh;
        if (ctrl.merge)
            result = {op_b[HALF_W-1:0], mac[HALF_W-1:0]};
        else
            result = mac;
    end
endmodule

// File: rtl/hmad_unit.sv
// Top of the half-word multiply-add unit. Picks a half of each of the
// first two operands, multiplies and adds, and registers the result with
// a valid flag and an illegal-immediate flag. Inputs are taken only in
// cycles with in_valid high. Reset is synchronous and active low.
module hmad_unit #(
    parameter int WORD_W = hmad_pkg::WORD_W,
    localparam int HALF_W = WORD_W / 2,
    localparam int N_MUL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic              is_signed,
    input  logic [6:0]        mode,
    input  logic              imm_a,
    input  logic              imm_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_illegal
);
    import hmad_pkg::*;

    ctrl_t             ctrl;
    logic [WORD_W-1:0] words  [N_MUL];
    logic [WORD_W-1:0] wide   [N_MUL];
    logic [N_MUL-1:0]  hi_sel;
    logic [N_MUL-1:0]  imm;
    logic [N_MUL-1:0]  nonzero;
    logic [N_MUL-1:0]  negative;
    logic [N_MUL-1:0]  bad_imm;
    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] result;

    // Unpack the control word and gather per-operand inputs
    always_comb begin
        ctrl      = ctrl_t'(mode);
        words[0]  = op_a;
        words[1]  = op_b;
        hi_sel    = {ctrl.hi_b, ctrl.hi_a};
        imm       = {imm_b, imm_a};
    end

    for (genvar g = 0; g < N_MUL; g++) begin : g_pick
        hmad_half_pick #(.WORD_W(WORD_W)) u_pick (
            .word     (words[g]),
            .take_hi  (hi_sel[g]),
            .sgn      (is_signed),
            .is_imm   (imm[g]),
            .wide     (wide[g]),
            .nonzero  (nonzero[g]),
            .negative (negative[g]),
            .bad_imm  (bad_imm[g])
        );
    end

    hmad_addend #(.WORD_W(WORD_W)) u_addend (
        .code   (ctrl.code),
        .op_c   (op_c),
        .addend (addend)
    );

    hmad_combine #(.WORD_W(WORD_W)) u_combine (
        .wide_a   (wide[0]),
        .wide_b   (wide[1]),
        .addend   (addend),
        .op_b     (op_b),
        .ctrl     (ctrl),
        .nonzero  (nonzero),
        .negative (negative),
        .result   (result)
    );

    // Output registers: capture on a strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= result;
                out_illegal <= |bad_imm;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R12
    AST_MERGE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1]) |=> out_result[WORD_W-1:HALF_W] == $past(op_b[HALF_W-1:0])); // R5
    AST_IMM_HI_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((imm_a && mode[5]) || (imm_b && mode[6]))) |=> out_illegal); // R11
    AST_NO_IMM_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !imm_a && !imm_b) |=> !out_illegal); // R11
endmodule

// File: tb/hmad_unit_bench.sv
// Directed bench for hmad_unit: one task per scenario, each checking itself.
module hmad_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        is_signed = 1'b0;
    logic [6:0]  mode = '0;
    logic        imm_a = 1'b0, imm_b = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    hmad_unit u_hmad_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .is_signed(is_signed),
        .mode(mode), .imm_a(imm_a), .imm_b(imm_b),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    // Reference built from the requirement text
    function automatic logic [31:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c, input logic sg,
                                             input logic [6:0] m);
        logic [15:0] ha = m[5] ? a[31:16] : a[15:0];
        logic [15:0] hb = m[6] ? b[31:16] : b[15:0];
        logic signed [31:0] xa = sg ? 32'(signed'(ha)) : {16'h0, ha};
        logic signed [31:0] xb = sg ? 32'(signed'(hb)) : {16'h0, hb};
        logic [31:0] p = 32'(xa * xb);
        logic [2:0]  cc = m[4:2];
        logic [31:0] add = (cc == 3'd1) ? {16'h0, c[15:0]} :
                           (cc == 3'd2) ? {16'h0, c[31:16]} : c;
        logic [31:0] r = (m[0] ? (p << 16) : p) + add;
        if (cc == 3'd3 && ha != 0 && hb != 0) begin
            if (sg && ha[15]) r = r - 32'd65536;
            if (sg && hb[15]) r = r - 32'd65536;
        end
        if (cc == 3'd4) r = r + (b << 16);
        if (m[1]) r = {b[15:0], r[15:0]};
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One transaction: drive at a falling edge, sample one cycle later
    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic sg, input logic [6:0] m, input logic ia, input logic ib,
                       output logic [31:0] res, output logic ill);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; is_signed = sg; mode = m;
        imm_a = ia; imm_b = ib; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_result;
        ill = out_illegal;
        check("R12 valid", {31'h0, out_valid}, 32'd1);
    endtask

    task automatic calc(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic sg, input logic [6:0] m);
        logic [31:0] r;
        logic il;
        run(a, b, c, sg, m, 1'b0, 1'b0, r, il);
        check(req, r, ref_calc(a, b, c, sg, m));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 reset valid", {31'h0, out_valid}, 32'd0);
        check("R12 reset result", out_result, 32'd0);
        check("R12 reset illegal", {31'h0, out_illegal}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] r; logic il;
        run(32'h0001_0003, 32'h0002_0005, 32'd7, 1'b0, 7'h00, 1'b0, 1'b0, r, il);
        check("R3 plain", r, 32'd22);
        calc("R3 wrap", 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 1'b0, 7'h00);
    endtask

    task automatic t_halves();
        logic [31:0] r; logic il;
        run(32'h0004_0003, 32'h0006_0005, 32'd0, 1'b0, 7'h20, 1'b0, 1'b0, r, il);
        check("R1 hi a", r, 32'd20);
        run(32'h0004_0003, 32'h0006_0005, 32'd0, 1'b0, 7'h60, 1'b0, 1'b0, r, il);
        check("R1 hi both", r, 32'd24);
    endtask

    task automatic t_sign();
        logic [31:0] r; logic il;
        run(32'h0000_FFFF, 32'd2, 32'd0, 1'b1, 7'h00, 1'b0, 1'b0, r, il);
        check("R2 signed", r, 32'hFFFF_FFFE);
        run(32'h0000_FFFF, 32'd2, 32'd0, 1'b0, 7'h00, 1'b0, 1'b0, r, il);
        check("R2 unsigned", r, 32'h0001_FFFE);
        calc("R2 signed hi", 32'h8000_1234, 32'hFFFE_0000, 32'd5, 1'b1, 7'h60);
    endtask

    task automatic t_shift();
        logic [31:0] r; logic il;
        run(32'd3, 32'd5, 32'd1, 1'b0, 7'h01, 1'b0, 1'b0, r, il);
        check("R4 post-shift", r, 32'h000F_0001);
        calc("R4 shift lo-addend", 32'h0000_1234, 32'h0000_0101, 32'hABCD_5555, 1'b0, 7'h05);
    endtask

    task automatic t_merge();
        logic [31:0] r; logic il;
        run(32'd3, 32'hAAAA_0005, 32'h0001_0001, 1'b0, 7'h02, 1'b0, 1'b0, r, il);
        check("R5 merge", r, 32'h0005_0010);
    endtask

    task automatic t_halfadd();
        logic [31:0] r; logic il;
        run(32'd2, 32'd3, 32'h1234_0010, 1'b0, 7'h04, 1'b0, 1'b0, r, il);
        check("R6 low half", r, 32'h0000_0016);
        run(32'd2, 32'd3, 32'hFFFF_0010, 1'b0, 7'h08, 1'b0, 1'b0, r, il);
        check("R6 high half", r, 32'h0001_0005);
    endtask

    task automatic t_sfix();
        logic [31:0] r; logic il;
        run(32'h0000_FFFF, 32'd2, 32'd0, 1'b1, 7'h0C, 1'b0, 1'b0, r, il);
        check("R7 one neg", r, 32'hFFFE_FFFE);
        run(32'h0000_FFFF, 32'h0000_FFFF, 32'd0, 1'b1, 7'h0C, 1'b0, 1'b0, r, il);
        check("R7 two neg", r, 32'hFFFE_0001);
        run(32'h0000_FFFF, 32'd0, 32'd9, 1'b1, 7'h0C, 1'b0, 1'b0, r, il);
        check("R7 zero gate", r, 32'd9);
        run(32'h0000_FFFF, 32'd2, 32'd0, 1'b0, 7'h0C, 1'b0, 1'b0, r, il);
        check("R7 unsigned", r, 32'h0001_FFFE);
    endtask

    task automatic t_bshift();
        logic [31:0] r; logic il;
        run(32'd2, 32'h0000_0003, 32'd1, 1'b0, 7'h10, 1'b0, 1'b0, r, il);
        check("R8 add b<<16", r, 32'h0003_0007);
    endtask

    task automatic t_reserved();
        for (int k = 5; k < 8; k++) begin
            logic [31:0] r0, r1; logic il;
            run(32'h0000_0102, 32'h0000_0304, 32'hDEAD_BEEF, 1'b0, 7'h00, 1'b0, 1'b0, r0, il);
            run(32'h0000_0102, 32'h0000_0304, 32'hDEAD_BEEF, 1'b0, 7'(k << 2), 1'b0, 1'b0, r1, il);
            check("R9 reserved code", r1, r0);
        end
    endtask

    task automatic t_swap();
        logic [6:0] ms [4] = '{7'h20, 7'h4C, 7'h25, 7'h69};
        for (int k = 0; k < 4; k++) begin
            logic [31:0] r0, r1; logic il;
            logic [6:0] m = ms[k];
            logic [6:0] sw = {m[5], m[6], m[4:0]};
            run(32'h8001_7FFF, 32'hFFFF_0003, 32'h0102_0304, 1'b1, m, 1'b0, 1'b0, r0, il);
            run(32'hFFFF_0003, 32'h8001_7FFF, 32'h0102_0304, 1'b1, sw, 1'b0, 1'b0, r1, il);
            check("R10 swap", r1, r0);
        end
    endtask

    task automatic t_illegal();
        logic [31:0] r; logic il;
        run(32'h0000_FFFF, 32'd1, 32'd0, 1'b0, 7'h00, 1'b1, 1'b0, r, il);
        check("R11 legal imm", {31'h0, il}, 32'd0);
        run(32'h0001_0000, 32'd1, 32'd0, 1'b0, 7'h00, 1'b1, 1'b0, r, il);
        check("R11 wide imm", {31'h0, il}, 32'd1);
        run(32'd1, 32'd1, 32'd0, 1'b0, 7'h40, 1'b0, 1'b1, r, il);
        check("R11 imm hi flag", {31'h0, il}, 32'd1);
        run(32'd1, 32'd1, 32'd0, 1'b0, 7'h40, 1'b1, 1'b0, r, il);
        check("R11 hi on register", {31'h0, il}, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] r; logic il;
        run(32'd6, 32'd7, 32'd0, 1'b0, 7'h00, 1'b0, 1'b0, r, il);
        @(negedge clk);
        op_a = 32'd100; op_b = 32'd100;
        @(negedge clk);
        check("R12 hold result", out_result, 32'd42);
        check("R12 idle valid", {31'h0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_halves();
        t_sign();
        t_shift();
        t_merge();
        t_halfadd();
        t_sfix();
        t_bshift();
        t_reserved();
        t_swap();
        t_illegal();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule